// File: doc/BRIEF.md
# Vertical Scaler Line Phase Sequencer

This block works out, for every output line of a vertical video scaler, which source line feeds it and with what fractional interpolation weight. It does not touch pixels. It gets a frame-start pulse, an optional field indication and a line strobe. For each output line it returns a source-line index, a 19-bit weight and a flag that marks a clamped start phase. A small write-only register port holds the settings: the step fraction, four signed start phases, the output line count and the mode bits. The line buffers and the filter arithmetic use these results to fetch and blend lines.

The step fraction is always at most one. A mode bit decides how it is used:
- **Enlarging:** the fraction is added once per output line, so every strobe requests one output line.
- **Reducing:** the fraction is added once per input line, so every strobe announces one input line, and an output line appears only when the phase crosses a whole line.

For interlaced material, the four start-phase registers are indexed by filter choice and field. This lets the two fields begin a quarter line apart. Settings can be double-buffered so that writes made during a frame apply only from the next frame start.

Top module: `vsq_line_phase_seq`

## Requirements
- R1: After reset all outputs are 0, including `enabled`. Line strobes have no effect until the first frame start.
- R2: Register 1 holds the 20-bit step fraction, with 19 fractional bits (0x80000 = 1.0). A written value above 0x80000 is stored as 0x80000.
- R3: Enlarging mode is control bit 4 = 0, with control bit 0 = 1. An accepted strobe produces `out_valid` after the next clock edge. Let p = start + k·step for output line k, where start is the selected phase sign-extended. Then `src_idx` = floor(p) and `weight` = the 19 fractional bits of p.
- R4: Reducing mode is control bit 4 = 1. For input strobe j (counted from 0), let q = start + (j+1)·step. An output line is produced when floor(max(q,0)) exceeds floor(max(q−step,0)). It then carries `src_idx` = j and `weight` = the fractional bits of q.
- R5: In enlarging mode, a negative p gives `src_idx` = 0, `weight` = the fractional bits of −p, and `clamped` = 1. Otherwise `clamped` = 0.
- R6: Registers 2 to 5 hold 21-bit two's-complement start phases (0x20000 = +0.25, 0x1E0000 = −0.25). The phase in register 2 + {control bit 8, f} is used, where the field selection f comes from control bits 13:12:
  - 0 or 2: field 0;
  - 1: the `field_in` pin, sampled at frame start;
  - 3: field 1.
- R7: With control bit 0 clear, the block is in bypass and `enabled` = 0. Each accepted strobe then produces one line with `src_idx` = strobe count since frame start, `weight` = 0 and `clamped` = 0.
- R8: Bit 0 of register 6 turns on double buffering. While it is set, writes to registers 0 to 5 take effect only at the next frame start. While it is clear, they take effect from the second clock edge after the write.
- R9: Control bits 29:16 hold the output line count minus one. `done` rises together with the last line's `out_valid`. Further strobes are ignored until the next frame start, as is a strobe in the same cycle as a frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register index |
| wr_data | input | 32 | Register write value |
| frame_start | input | 1 | Frame start pulse |
| field_in | input | 1 | Current field, sampled at frame start |
| line_strobe | input | 1 | Line request (enlarging) or input line arrival (reducing) |
| out_valid | output | 1 | An output line is reported this cycle |
| src_idx | output | 14 | Source line index |
| weight | output | 19 | Fractional interpolation weight |
| clamped | output | 1 | Negative start phase clamped to line 0 |
| done | output | 1 | Last output line of the frame |
| enabled | output | 1 | Working enable bit |

## Verification
Two conditions are the hardest to reach from the ports:
- A reducing frame whose start phase is negative. Here the first whole-line crossing must come from below zero, not from the first fractional carry.
- A mid-frame write while double buffering is on. Here the old step has to survive until the next frame.

Directed frames set up both conditions: a frame with a −0.25 start phase on a 2/3 step, and a frame with a step write between strobes, run once with buffering on and once with it off. After these, seeded random frames draw a step, four start phases, field and filter choices and a line count. Their results are compared with closed-form expressions of the phase position.

// File: rtl/vsq_pkg.sv
package vsq_pkg;

   typedef enum logic [2:0] {
      REG_CTRL   = 3'd0,
      REG_FACTOR = 3'd1,
      REG_OFS0   = 3'd2,
      REG_OFS1   = 3'd3,
      REG_OFS2   = 3'd4,
      REG_OFS3   = 3'd5,
      REG_SHADOW = 3'd6
   } vsq_addr_e;

   localparam int CTL_EN_BIT    = 0;
   localparam int CTL_DOWN_BIT  = 4;
   localparam int CTL_FILT_BIT  = 8;
   localparam int CTL_FMODE_LSB = 12;
   localparam int CTL_LINES_LSB = 16;

   typedef enum logic [1:0] {
      FLD_PROG = 2'd0,
      FLD_PIN  = 2'd1,
      FLD_TOP  = 2'd2,
      FLD_BOT  = 2'd3
   } vsq_fmode_e;

   function automatic logic vsq_pick_field(input logic [1:0] fm, input logic pin);
      case (vsq_fmode_e'(fm))
         FLD_PIN: return pin;
         FLD_BOT: return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/vsq_regs.sv
module vsq_regs
   import vsq_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int FACT_W     = 20,
   parameter int PH_W       = 21,
   parameter int CNT_W      = 14,
   parameter bit HAS_SHADOW = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [2:0]          wr_addr,
   input  logic [DATA_W-1:0]   wr_data,
   input  logic                frame_start,
   output logic                cur_en,
   output logic                cur_down,
   output logic [CNT_W-1:0]    cur_lines_m1,
   output logic [FACT_W-1:0]   cur_factor,
   output logic                nxt_filt,
   output logic [1:0]          nxt_fmode,
   output logic [4*PH_W-1:0]   nxt_ofs
);
   localparam int OFS_LSB = 0;
   localparam int FAC_LSB = OFS_LSB + 4*PH_W;
   localparam int LIN_LSB = FAC_LSB + FACT_W;
   localparam int FM_LSB  = LIN_LSB + CNT_W;
   localparam int FILT_B  = FM_LSB + 2;
   localparam int DOWN_B  = FILT_B + 1;
   localparam int EN_B    = DOWN_B + 1;
   localparam int CFG_W   = EN_B + 1;
   localparam logic [FACT_W-1:0] UNITY = FACT_W'(1) << (FACT_W-1);

   if (DATA_W < CTL_LINES_LSB + CNT_W) begin : g_chk_data
      $error("vsq_regs: DATA_W too small for control layout");
   end
   if (PH_W > DATA_W || FACT_W > DATA_W) begin : g_chk_fields
      $error("vsq_regs: field wider than data bus");
   end

   logic              st_en, st_down, st_filt;
   logic [1:0]        st_fmode;
   logic [CNT_W-1:0]  st_lines;
   logic [FACT_W-1:0] st_fac;
   logic [PH_W-1:0]   st_ofs [4];
   logic [CFG_W-1:0]  st_cfg, cur_cfg, nxt_cfg;
   logic [FACT_W-1:0] wr_fac;

   assign wr_fac = (wr_data[FACT_W-1:0] > UNITY) ? UNITY : wr_data[FACT_W-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_en    <= 1'b0;
         st_down  <= 1'b0;
         st_filt  <= 1'b0;
         st_fmode <= '0;
         st_lines <= '0;
         st_fac   <= '0;
      end else if (wr_en) begin
         if (wr_addr == REG_CTRL) begin
            st_en    <= wr_data[CTL_EN_BIT];
            st_down  <= wr_data[CTL_DOWN_BIT];
            st_filt  <= wr_data[CTL_FILT_BIT];
            st_fmode <= wr_data[CTL_FMODE_LSB +: 2];
            st_lines <= wr_data[CTL_LINES_LSB +: CNT_W];
         end
         if (wr_addr == REG_FACTOR) st_fac <= wr_fac;
      end
   end

   for (genvar g = 0; g < 4; g++) begin : g_ofs
      always_ff @(posedge clk) begin
         if (!rst_n)
            st_ofs[g] <= '0;
         else if (wr_en && wr_addr == 3'(REG_OFS0 + g))
            st_ofs[g] <= wr_data[PH_W-1:0];
      end
   end

   assign st_cfg = {st_en, st_down, st_filt, st_fmode, st_lines, st_fac,
                    st_ofs[3], st_ofs[2], st_ofs[1], st_ofs[0]};

   if (HAS_SHADOW) begin : g_shadow
      logic             shadow_on;
      logic             take;
      logic [CFG_W-1:0] wk_cfg;

      always_ff @(posedge clk) begin
         if (!rst_n)
            shadow_on <= 1'b0;
         else if (wr_en && wr_addr == REG_SHADOW)
            shadow_on <= wr_data[0];
      end

      assign take = !shadow_on || frame_start;

      always_ff @(posedge clk) begin
         if (!rst_n)
            wk_cfg <= '0;
         else if (take)
            wk_cfg <= st_cfg;
      end

      assign cur_cfg = wk_cfg;
      assign nxt_cfg = take ? st_cfg : wk_cfg;
   end else begin : g_direct
      assign cur_cfg = st_cfg;
      assign nxt_cfg = st_cfg;
   end

   assign cur_en       = cur_cfg[EN_B];
   assign cur_down     = cur_cfg[DOWN_B];
   assign cur_lines_m1 = cur_cfg[LIN_LSB +: CNT_W];
   assign cur_factor   = cur_cfg[FAC_LSB +: FACT_W];
   assign nxt_filt     = nxt_cfg[FILT_B];
   assign nxt_fmode    = nxt_cfg[FM_LSB +: 2];
   assign nxt_ofs      = nxt_cfg[OFS_LSB +: 4*PH_W];

endmodule

// File: rtl/vsq_phase.sv
module vsq_phase #(
   parameter int IDX_W  = 14,
   parameter int FRAC_W = 19,
   parameter int FACT_W = 20,
   parameter int PH_W   = 21
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [PH_W-1:0]   start_ofs,
   input  logic              step,
   input  logic              en,
   input  logic              down,
   input  logic [FACT_W-1:0] factor,
   output logic              emit,
   output logic [IDX_W-1:0]  idx,
   output logic [FRAC_W-1:0] weight,
   output logic              clamp
);
   localparam int ACC_W = IDX_W + FRAC_W + 1;
   localparam logic signed [ACC_W-1:0] ONE_S = ACC_W'(1) << FRAC_W;

   if (FACT_W != FRAC_W + 1) begin : g_chk_fact
      $error("vsq_phase: FACT_W must be FRAC_W+1");
   end
   if (ACC_W <= PH_W) begin : g_chk_acc
      $error("vsq_phase: accumulator narrower than phase offset");
   end

   logic signed [ACC_W-1:0] acc_q, acc_d, sum, fac_ext, ofs_ext, mag;
   logic [IDX_W-1:0]        cnt_q, cnt_d;
   logic                    carry;

   assign fac_ext = signed'({{(ACC_W-FACT_W){1'b0}}, factor});
   assign ofs_ext = signed'({{(ACC_W-PH_W){start_ofs[PH_W-1]}}, start_ofs});
   assign sum     = acc_q + fac_ext;
   assign carry   = (sum >= ONE_S);
   assign mag     = -acc_q;

   always_comb begin
      acc_d  = acc_q;
      cnt_d  = cnt_q;
      emit   = 1'b0;
      idx    = '0;
      weight = '0;
      clamp  = 1'b0;
      if (start) begin
         acc_d = ofs_ext;
         cnt_d = '0;
      end else if (step) begin
         if (!en) begin
            emit  = 1'b1;
            idx   = cnt_q;
            cnt_d = cnt_q + 1'b1;
         end else if (down) begin
            cnt_d = cnt_q + 1'b1;
            acc_d = carry ? (sum - ONE_S) : sum;
            if (carry) begin
               emit   = 1'b1;
               idx    = cnt_q;
               weight = sum[FRAC_W-1:0];
            end
         end else begin
            emit  = 1'b1;
            acc_d = sum;
            if (acc_q[ACC_W-1]) begin
               clamp  = 1'b1;
               weight = mag[FRAC_W-1:0];
            end else begin
               idx    = acc_q[FRAC_W +: IDX_W];
               weight = acc_q[FRAC_W-1:0];
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q <= '0;
         cnt_q <= '0;
      end else begin
         acc_q <= acc_d;
         cnt_q <= cnt_d;
      end
   end

endmodule

// File: rtl/vsq_frame.sv
module vsq_frame #(
   parameter int CNT_W = 14
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             strobe,
   input  logic             emit,
   input  logic [CNT_W-1:0] lines_m1,
   output logic             accept,
   output logic             last
);
   logic             active_q;
   logic [CNT_W-1:0] cnt_q;

   assign accept = strobe && active_q && !start;
   assign last   = emit && (cnt_q == lines_m1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         cnt_q    <= '0;
      end else if (start) begin
         active_q <= 1'b1;
         cnt_q    <= '0;
      end else if (emit) begin
         if (last) active_q <= 1'b0;
         else      cnt_q    <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/vsq_line_phase_seq.sv
module vsq_line_phase_seq
   import vsq_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int IDX_W      = 14,
   parameter int FRAC_W     = 19,
   parameter int CNT_W      = 14,
   parameter bit HAS_SHADOW = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [2:0]        wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              frame_start,
   input  logic              field_in,
   input  logic              line_strobe,
   output logic              out_valid,
   output logic [IDX_W-1:0]  src_idx,
   output logic [FRAC_W-1:0] weight,
   output logic              clamped,
   output logic              done,
   output logic              enabled
);
   localparam int FACT_W = FRAC_W + 1;
   localparam int PH_W   = FRAC_W + 2;

   logic              cur_en, cur_down, nxt_filt, fld;
   logic [1:0]        nxt_fmode;
   logic [CNT_W-1:0]  cur_lines_m1;
   logic [FACT_W-1:0] cur_factor;
   logic [4*PH_W-1:0] nxt_ofs;
   logic [PH_W-1:0]   sel_ofs;
   logic [1:0]        ofs_sel;
   logic              accept, emit, clamp_c, last;
   logic [IDX_W-1:0]  idx_c;
   logic [FRAC_W-1:0] weight_c;

   vsq_regs #(
      .DATA_W(DATA_W), .FACT_W(FACT_W), .PH_W(PH_W),
      .CNT_W(CNT_W), .HAS_SHADOW(HAS_SHADOW)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .frame_start(frame_start),
      .cur_en(cur_en), .cur_down(cur_down), .cur_lines_m1(cur_lines_m1),
      .cur_factor(cur_factor), .nxt_filt(nxt_filt), .nxt_fmode(nxt_fmode),
      .nxt_ofs(nxt_ofs)
   );

   assign fld     = vsq_pick_field(nxt_fmode, field_in);
   assign ofs_sel = {nxt_filt, fld};
   assign sel_ofs = nxt_ofs[ofs_sel*PH_W +: PH_W];

   vsq_frame #(.CNT_W(CNT_W)) u_frame (
      .clk(clk), .rst_n(rst_n), .start(frame_start), .strobe(line_strobe),
      .emit(emit), .lines_m1(cur_lines_m1), .accept(accept), .last(last)
   );

   vsq_phase #(
      .IDX_W(IDX_W), .FRAC_W(FRAC_W), .FACT_W(FACT_W), .PH_W(PH_W)
   ) u_phase (
      .clk(clk), .rst_n(rst_n), .start(frame_start), .start_ofs(sel_ofs),
      .step(accept), .en(cur_en), .down(cur_down), .factor(cur_factor),
      .emit(emit), .idx(idx_c), .weight(weight_c), .clamp(clamp_c)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         src_idx   <= '0;
         weight    <= '0;
         clamped   <= 1'b0;
         done      <= 1'b0;
      end else begin
         out_valid <= emit;
         src_idx   <= idx_c;
         weight    <= weight_c;
         clamped   <= clamp_c;
         done      <= last;
      end
   end

   assign enabled = cur_en;

endmodule

// File: rtl/vsq_line_phase_seq_chk.sv
module vsq_line_phase_seq_chk #(
   parameter int IDX_W  = 14,
   parameter int FRAC_W = 19
) (
   input logic              clk,
   input logic              rst_n,
   input logic              frame_start,
   input logic              line_strobe,
   input logic              out_valid,
   input logic [IDX_W-1:0]  src_idx,
   input logic [FRAC_W-1:0] weight,
   input logic              clamped,
   input logic              done,
   input logic              enabled
);
   AST_DONE_WITH_LINE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> out_valid); // R9
   AST_QUIET_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !out_valid); // R9
   AST_LINE_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ($past(line_strobe) && !$past(frame_start))); // R3
   AST_CLAMP_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
      clamped |-> (out_valid && src_idx == '0)); // R5
   AST_BYPASS_FLAT: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !$past(enabled)) |-> (weight == '0 && !clamped)); // R7
endmodule

bind vsq_line_phase_seq vsq_line_phase_seq_chk #(
   .IDX_W(IDX_W), .FRAC_W(FRAC_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
   .line_strobe(line_strobe), .out_valid(out_valid), .src_idx(src_idx),
   .weight(weight), .clamped(clamped), .done(done), .enabled(enabled)
);

// File: tb/vsq_line_phase_seq_bench.sv
module vsq_line_phase_seq_bench;
   localparam longint ONE  = 64'h80000;
   localparam longint MASK = 64'h7FFFF;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic        frame_start = 1'b0;
   logic        field_in = 1'b0;
   logic        line_strobe = 1'b0;
   logic        out_valid, clamped, done, enabled;
   logic [13:0] src_idx;
   logic [18:0] weight;

   int checks = 0;
   int failures = 0;
   longint ofs_tb [4];

   always #2 clk = ~clk;

   vsq_line_phase_seq u_vsq_line_phase_seq (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .frame_start(frame_start), .field_in(field_in),
      .line_strobe(line_strobe), .out_valid(out_valid), .src_idx(src_idx),
      .weight(weight), .clamped(clamped), .done(done), .enabled(enabled)
   );

   task automatic chk(input string req, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s act=%0d exp=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input longint d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 3'(a); wr_data = 32'(d);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic frame(input logic fld);
      @(negedge clk);
      frame_start = 1'b1; field_in = fld;
      @(negedge clk);
      frame_start = 1'b0;
   endtask

   task automatic strobe();
      @(negedge clk);
      line_strobe = 1'b1;
      @(negedge clk);
      line_strobe = 1'b0;
   endtask

   function automatic longint ctrl(input int en, input int dn, input int filt,
                                   input int fm, input int lines);
      return (longint'(lines - 1) << 16) | (longint'(fm) << 12) |
             (longint'(filt) << 8) | (longint'(dn) << 4) | longint'(en);
   endfunction

   function automatic longint fl0(input longint x);
      return (x < 0) ? 0 : (x >>> 19);
   endfunction

   task automatic expect_line(input string req, input longint i, input longint w,
                              input longint c, input longint d);
      chk({req, " valid"}, out_valid, 1);
      chk({req, " idx"}, src_idx, i);
      chk({req, " weight"}, weight, w);
      chk({req, " clamp"}, clamped, c);
      chk({req, " done"}, done, d);
   endtask

   // programs everything, starts a frame and checks each strobe against the model
   task automatic run_frame(input string req, input int en, input int dn,
                            input int filt, input int fm, input logic fld,
                            input longint f, input int lines, input int nstr);
      longint ofs, p, q;
      int k, fs;
      bit fin;
      for (int r = 0; r < 4; r++) wr(2 + r, ofs_tb[r] & 64'h1FFFFF);
      wr(1, f);
      wr(0, ctrl(en, dn, filt, fm, lines));
      if (f > ONE) f = ONE;                      // R2 saturation
      fs = (fm == 1) ? int'(fld) : (fm == 3) ? 1 : 0;
      ofs = ofs_tb[filt * 2 + fs];               // R6 selection
      frame(fld);
      k = 0; fin = 0;
      for (int j = 0; j < nstr; j++) begin
         strobe();
         if (fin) begin
            chk({req, " R9 ignored"}, out_valid, 0);
         end else if (en == 0) begin
            expect_line({req, " R7"}, j, 0, 0, (k == lines - 1));
            k++;
         end else if (dn == 1) begin
            q = ofs + longint'(j + 1) * f;
            if (fl0(q) > fl0(q - f)) begin
               expect_line({req, " R4"}, j, q & MASK, 0, (k == lines - 1));
               k++;
            end else begin
               chk({req, " R4 no line"}, out_valid, 0);
            end
         end else begin
            p = ofs + longint'(k) * f;
            if (p < 0) expect_line({req, " R5"}, 0, (-p) & MASK, 1, (k == lines - 1));
            else       expect_line({req, " R3"}, p >>> 19, p & MASK, 0, (k == lines - 1));
            k++;
         end
         if (k == lines) fin = 1;
      end
   endtask

   initial begin
      #(200000 * 4);
      failures++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state, strobe before any frame is ignored
      chk("R1 valid", out_valid, 0);
      chk("R1 enabled", enabled, 0);
      chk("R1 done", done, 0);
      strobe();
      chk("R1 early strobe", out_valid, 0);

      for (int r = 0; r < 4; r++) ofs_tb[r] = 0;
      // R2: oversized factor behaves as 1.0
      run_frame("R2", 1, 0, 0, 0, 0, 64'hFFFFF, 3, 3);
      chk("R1 enabled set", enabled, 1);
      // R3 + R9: half step, six lines, two extra strobes ignored
      run_frame("R3", 1, 0, 0, 0, 0, 64'h40000, 6, 8);
      // R5 + R6: field from pin, field 1 phase is -0.25
      ofs_tb[0] = 0; ofs_tb[1] = -64'h20000; ofs_tb[2] = 64'h10000; ofs_tb[3] = 64'h20000;
      run_frame("R5 pin1", 1, 0, 0, 1, 1, 64'h30000, 4, 4);
      run_frame("R6 pin0", 1, 0, 0, 1, 0, 64'h30000, 3, 3);
      run_frame("R6 filt bot", 1, 0, 1, 3, 0, 64'h30000, 3, 3);
      run_frame("R6 filt top", 1, 0, 1, 2, 1, 64'h30000, 3, 3);
      // R4: reducing by 2/3, progressive and with -0.25 start
      run_frame("R4 prog", 1, 1, 0, 0, 0, 64'h55555, 4, 10);
      run_frame("R4 neg", 1, 1, 0, 1, 1, 64'h55555, 4, 10);
      run_frame("R4 unity", 1, 1, 0, 0, 0, ONE, 3, 4);
      // R7: bypass
      run_frame("R7", 0, 0, 0, 0, 0, 64'h20000, 3, 5);
      chk("R7 enabled", enabled, 0);

      // R9: strobe together with frame start is ignored
      ofs_tb[0] = 0;
      for (int r = 0; r < 4; r++) wr(2 + r, 0);
      wr(1, 64'h40000);
      wr(0, ctrl(1, 0, 0, 0, 4));
      @(negedge clk);
      frame_start = 1'b1; line_strobe = 1'b1;
      @(negedge clk);
      frame_start = 1'b0; line_strobe = 1'b0;
      chk("R9 start+strobe", out_valid, 0);
      strobe();
      expect_line("R9 first line", 0, 0, 0, 0);

      // R8: double buffering on, mid-frame step write held off
      wr(6, 1);
      wr(1, 64'h40000);
      wr(0, ctrl(1, 0, 0, 0, 8));
      frame(0);
      strobe(); expect_line("R8 a", 0, 0, 0, 0);
      strobe(); expect_line("R8 b", 0, 64'h40000, 0, 0);
      wr(1, ONE);
      repeat (2) @(negedge clk);
      strobe(); expect_line("R8 held c", 1, 0, 0, 0);
      strobe(); expect_line("R8 held d", 1, 64'h40000, 0, 0);
      frame(0);
      strobe(); expect_line("R8 new a", 0, 0, 0, 0);
      strobe(); expect_line("R8 new b", 1, 0, 0, 0);
      // R8: double buffering off, write applies mid-frame
      wr(6, 0);
      wr(1, 64'h40000);
      repeat (2) @(negedge clk);
      strobe(); expect_line("R8 live c", 2, 0, 0, 0);
      strobe(); expect_line("R8 live d", 2, 64'h40000, 0, 0);

      // random frames
      for (int n = 0; n < 30; n++) begin
         int dn, lines, fm, filt;
         logic fld;
         longint f;
         dn = int'($urandom_range(0, 1));
         lines = int'($urandom_range(1, 8));
         fm = int'($urandom_range(0, 3));
         filt = int'($urandom_range(0, 1));
         fld = 1'($urandom_range(0, 1));
         f = longint'($urandom_range(32'h8000, 32'h80000));
         for (int r = 0; r < 4; r++)
            ofs_tb[r] = longint'($urandom_range(0, 32'h7FFFE)) - 64'h3FFFF;
         if (dn == 1) run_frame("R4 rand", 1, 1, filt, fm, fld, f, lines, lines * 17 + 2);
         else         run_frame("R3 rand", 1, 0, filt, fm, fld, f, lines, lines + 2);
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule